// File: doc/BRIEF.md
# Flash Command Interrupt Status Unit

This block is the register front end of a flash controller. Software reaches it over a small synchronous register bus with a 2-bit register select, a write strobe and a read strobe. Through this bus it writes commands, programs the system configuration and inspects and acknowledges interrupt and error state. The unit decodes each accepted command code. Load, program and erase codes are passed to an external array engine as a one-cycle request that carries an operation class. Reset codes re-initialise the registers. Housekeeping codes complete at once. Unknown codes are flagged as command errors.

The array engine reports completion with a done pulse and an error flag. That pulse sets the class bit and the master pending bit in the interrupt register, and on error it sets the error bits in the status register. The interrupt output polarity is chosen by a configuration bit. New commands are refused while the master bit is pending, so software must acknowledge an interrupt before it issues the next command.

Sequencing is held in a two-state machine. In S_IDLE the engine is free. Transition T_LAUNCH moves to S_BUSY when an array command is accepted. In S_BUSY an operation is outstanding, and transition T_FINISH returns to S_IDLE on the engine's done pulse.

Top module: `fcis_top`

## Requirements
- R1: After the asynchronous reset (rst_n low), the registers read as follows: interrupt 0x8080, status 0x0000, configuration 0x40C0, command 0x0000. rdy is 1 and irq is 1. The register select codes are 0 command, 1 configuration, 2 status and 3 interrupt.
- R2: A host write to the interrupt register (select 3) stores the bitwise AND of the written value and the current contents.
- R3: When an interrupt-register write leaves bit 15 clear, status bits 13:10 are cleared on the same edge. When bit 15 stays set, the status bits keep their value.
- R4: A command write (select 0) has no effect while interrupt bit 15 is set or while the machine is in S_BUSY. The command register keeps its old value and no engine request is made.
- R5: irq equals interrupt bit 15 XOR the inverse of configuration bit 6.
- R6: A configuration read returns the stored value with bits 4:0 forced to zero. Host writes to the status register (select 2) are ignored.
- R7: rdy takes the value of bit 7 of each word written to the configuration register.
- R8: An accepted array command issues eng_req for exactly one cycle and enters S_BUSY. eng_op is 0 for load (codes 0x0000, 0x0013), 1 for program (0x0080, 0x001A, 0x001B) and 2 for erase (0x0094, 0x0095, 0x0030).
- R9: eng_done in S_BUSY sets interrupt bit 15 together with the class bit: load bit 7, program bit 6, erase bit 5. With eng_err set, it also sets status bit 10 and the class error bit: load bit 13, program bit 12, erase bit 11.
- R10: An accepted code outside every defined set sets status bit 10 and interrupt bit 15 on the accept edge.
- R11: The reset codes 0x00F0 and 0x00F3 set interrupt to 0x8010, status to 0, configuration to 0x40C0, command to 0 and rdy to 1.
- R12: The codes 0x0023, 0x0027, 0x002A, 0x002C, 0x0065 and 0x0071 set only interrupt bit 15. Code 0x00B0 changes nothing but the command register.
- R13: When an interrupt-register write and eng_done fall on the same edge, the AND-mask and error wipe are applied first, and then the completion bits are set.
- R14: A read strobe returns the selected register on host_rdata with host_rvalid high in the following cycle. host_rvalid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| irq | output | 1 | Interrupt with programmable polarity |
| rdy | output | 1 | Ready line driven from configuration bit 7 |
| eng_req | output | 1 | One-cycle request to the array engine |
| eng_op | output | 2 | Operation class for the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error flag, qualified by eng_done |

## Verification
The bench aims at the interactions between acknowledgement and completion. One case is a done pulse that lands on the same edge as a clearing write. A design that applies the mask after the set would lose the new load bit, and one that wipes errors after the set would drop the fresh load error. Command refusal is tested both with the master bit pending and with an operation still outstanding. A design that leaked either case would overwrite the command register or issue a second engine request. Partial acknowledgement that keeps bit 15 must leave the error bits intact. Polarity flips and configuration writes are checked against irq and rdy directly.

// File: rtl/fcis_pkg.sv
package fcis_pkg;
    localparam int REG_W = 16;
    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CFG  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;
    localparam logic [SEL_W-1:0] SEL_INT  = 2'd3;

    localparam int IB_MASTER = 15;
    localparam int IB_RESET  = 4;
    localparam int IB_ERASE  = 5;
    localparam int IB_PROG   = 6;
    localparam int IB_LOAD   = 7;

    localparam int SB_CMD   = 10;
    localparam int SB_ERASE = 11;
    localparam int SB_PROG  = 12;
    localparam int SB_LOAD  = 13;

    localparam int CB_POL = 6;
    localparam int CB_RDY = 7;

    localparam logic [REG_W-1:0] INT_COLD  = 16'h8080;
    localparam logic [REG_W-1:0] INT_WARM  = 16'h8010;
    localparam logic [REG_W-1:0] CFG_INIT  = 16'h40C0;
    localparam logic [REG_W-1:0] CFG_RMASK = 16'hFFE0;
    localparam logic [REG_W-1:0] ERR_MASK  = 16'h3C00;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        K_ARRAY,
        K_RESET,
        K_SIMPLE,
        K_NOP,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e kind;
        op_e   op;
    } dec_t;

    typedef enum logic {
        S_IDLE,
        S_BUSY
    } state_e;
endpackage

// File: rtl/fcis_decode.sv
module fcis_decode
    import fcis_pkg::*;
(
    input  logic [REG_W-1:0] code,
    output dec_t             dec
);
    always_comb begin
        dec.op = OP_LOAD;
        unique case (code)
            16'h0000, 16'h0013: begin
                dec.kind = K_ARRAY;
                dec.op   = OP_LOAD;
            end
            16'h0080, 16'h001A, 16'h001B: begin
                dec.kind = K_ARRAY;
                dec.op   = OP_PROG;
            end
            16'h0094, 16'h0095, 16'h0030: begin
                dec.kind = K_ARRAY;
                dec.op   = OP_ERASE;
            end
            16'h00F0, 16'h00F3:
                dec.kind = K_RESET;
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0065, 16'h0071:
                dec.kind = K_SIMPLE;
            16'h00B0:
                dec.kind = K_NOP;
            default:
                dec.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/fcis_seq.sv
module fcis_seq
    import fcis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  op_e  launch_op,
    input  logic eng_done,
    input  logic eng_err,
    output logic idle,
    output logic eng_req,
    output op_e  eng_op,
    output logic fin,
    output logic fin_err
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (launch)   state_d = S_BUSY;   // T_LAUNCH
            S_BUSY: if (eng_done) state_d = S_IDLE;   // T_FINISH
            default:              state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_req <= 1'b0;
            eng_op  <= OP_LOAD;
        end else begin
            eng_req <= (state_q == S_IDLE) && launch;
            if ((state_q == S_IDLE) && launch) eng_op <= launch_op;
        end
    end

    assign idle    = (state_q == S_IDLE);
    assign fin     = (state_q == S_BUSY) && eng_done;
    assign fin_err = fin && eng_err;
endmodule

// File: rtl/fcis_regs.sv
module fcis_regs
    import fcis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    output logic             host_rvalid,
    input  logic             idle,
    input  logic             fin,
    input  op_e              fin_op,
    input  logic             fin_err,
    output logic             launch,
    output op_e              launch_op,
    output logic             irq,
    output logic             rdy,
    output logic [REG_W-1:0] int_q,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] cmd_q,
    output logic [REG_W-1:0] cfg_q
);
    logic [REG_W-1:0] int_d, stat_d, cmd_d, cfg_d, masked;
    logic             rdy_d, wr_cmd, wr_cfg, wr_int, accept;
    dec_t             dec;

    fcis_decode i_dec (.code(host_wdata), .dec(dec));

    assign wr_cmd    = host_wr && (host_sel == SEL_CMD);
    assign wr_cfg    = host_wr && (host_sel == SEL_CFG);
    assign wr_int    = host_wr && (host_sel == SEL_INT);
    assign accept    = wr_cmd && !int_q[IB_MASTER] && idle;
    assign launch    = accept && (dec.kind == K_ARRAY);
    assign launch_op = dec.op;
    assign masked    = int_q & host_wdata;

    always_comb begin
        int_d  = int_q;
        stat_d = stat_q;
        cmd_d  = cmd_q;
        cfg_d  = cfg_q;
        rdy_d  = rdy;
        if (wr_int) begin
            int_d = masked;
            if (!masked[IB_MASTER]) stat_d = stat_q & ~ERR_MASK;
        end
        if (wr_cfg) begin
            cfg_d = host_wdata;
            rdy_d = host_wdata[CB_RDY];
        end
        if (accept) begin
            cmd_d = host_wdata;
            unique case (dec.kind)
                K_SIMPLE: int_d[IB_MASTER] = 1'b1;
                K_BAD: begin
                    int_d[IB_MASTER] = 1'b1;
                    stat_d[SB_CMD]   = 1'b1;
                end
                K_RESET: begin
                    cmd_d  = '0;
                    int_d  = INT_WARM;
                    stat_d = '0;
                    cfg_d  = CFG_INIT;
                    rdy_d  = 1'b1;
                end
                default: ;
            endcase
        end
        if (fin) begin
            int_d[IB_MASTER] = 1'b1;
            if (fin_err) stat_d[SB_CMD] = 1'b1;
            unique case (fin_op)
                OP_LOAD: begin
                    int_d[IB_LOAD] = 1'b1;
                    if (fin_err) stat_d[SB_LOAD] = 1'b1;
                end
                OP_PROG: begin
                    int_d[IB_PROG] = 1'b1;
                    if (fin_err) stat_d[SB_PROG] = 1'b1;
                end
                default: begin
                    int_d[IB_ERASE] = 1'b1;
                    if (fin_err) stat_d[SB_ERASE] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= INT_COLD;
            stat_q <= '0;
            cmd_q  <= '0;
            cfg_q  <= CFG_INIT;
            rdy    <= 1'b1;
        end else begin
            int_q  <= int_d;
            stat_q <= stat_d;
            cmd_q  <= cmd_d;
            cfg_q  <= cfg_d;
            rdy    <= rdy_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) begin
                unique case (host_sel)
                    SEL_CMD:  host_rdata <= cmd_q;
                    SEL_CFG:  host_rdata <= cfg_q & CFG_RMASK;
                    SEL_STAT: host_rdata <= stat_q;
                    default:  host_rdata <= int_q;
                endcase
            end
        end
    end

    assign irq = int_q[IB_MASTER] ^ ~cfg_q[CB_POL];
endmodule

// File: rtl/fcis_top.sv
module fcis_top
    import fcis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    output logic             host_rvalid,
    output logic             irq,
    output logic             rdy,
    output logic             eng_req,
    output logic [1:0]       eng_op,
    input  logic             eng_done,
    input  logic             eng_err
);
    logic             idle_w, launch_w, fin_w, fin_err_w;
    op_e              launch_op_w, eng_op_w;
    logic [REG_W-1:0] int_w, stat_w, cmd_w, cfg_w;

    fcis_seq i_seq (
        .clk(clk), .rst_n(rst_n),
        .launch(launch_w), .launch_op(launch_op_w),
        .eng_done(eng_done), .eng_err(eng_err),
        .idle(idle_w), .eng_req(eng_req), .eng_op(eng_op_w),
        .fin(fin_w), .fin_err(fin_err_w)
    );

    fcis_regs i_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .idle(idle_w), .fin(fin_w), .fin_op(eng_op_w), .fin_err(fin_err_w),
        .launch(launch_w), .launch_op(launch_op_w),
        .irq(irq), .rdy(rdy),
        .int_q(int_w), .stat_q(stat_w), .cmd_q(cmd_w), .cfg_q(cfg_w)
    );

    assign eng_op = eng_op_w;
endmodule

// File: rtl/fcis_sva.sv
module fcis_sva
    import fcis_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [SEL_W-1:0] host_sel,
    input logic [REG_W-1:0] host_wdata,
    input logic [REG_W-1:0] host_rdata,
    input logic             rdy,
    input logic             eng_req,
    input logic             fin,
    input logic [REG_W-1:0] int_q,
    input logic [REG_W-1:0] stat_q,
    input logic [REG_W-1:0] cmd_q,
    input logic [REG_W-1:0] cfg_q
);
    AST_AND_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_INT && !fin) |=> int_q == ($past(int_q) & $past(host_wdata))); // R2

    AST_ERR_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_INT && !fin && !(int_q[IB_MASTER] && host_wdata[IB_MASTER]))
        |=> stat_q[SB_LOAD:SB_CMD] == 4'b0000); // R3

    AST_CMD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_CMD && int_q[IB_MASTER]) |=> $stable(cmd_q)); // R4

    AST_CFG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == SEL_CFG) |=> host_rdata[4:0] == 5'b00000); // R6

    AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_CFG) |=> rdy == $past(host_wdata[CB_RDY])); // R7

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req); // R8

    AST_FIN_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> int_q[IB_MASTER]); // R9

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr) |=> $stable(cfg_q)); // R6
endmodule

bind fcis_top fcis_sva i_sva (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rdy(rdy), .eng_req(eng_req), .fin(fin_w),
    .int_q(int_w), .stat_q(stat_w), .cmd_q(cmd_w), .cfg_q(cfg_w)
);

// File: tb/test_fcis_top.sv
`timescale 1ns/1ps
module test_fcis_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        host_rvalid, irq, rdy, eng_req;
    logic [1:0]  eng_op;
    logic        eng_done = 1'b0, eng_err = 1'b0;

    int checks = 0, failures = 0;
    bit finished = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    fcis_top i_fcis_top (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .irq(irq), .rdy(rdy), .eng_req(eng_req), .eng_op(eng_op),
        .eng_done(eng_done), .eng_err(eng_err)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when the design returns it (R14)
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R14 actual=unexpected_rvalid expected=no_read");
            end else begin
                chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [15:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_sel = s;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic done(input logic err);
        @(negedge clk);
        eng_done = 1'b1; eng_err = err;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 cold reset values
        chk("R1 irq", {15'h0, irq}, 16'h1);
        chk("R1 rdy", {15'h0, rdy}, 16'h1);
        rd(2'd3, 16'h8080, "R1 int");
        rd(2'd2, 16'h0000, "R1 status");
        rd(2'd1, 16'h40C0, "R1 cfg");
        rd(2'd0, 16'h0000, "R1 cmd");
        @(negedge clk);
        chk("R14 rvalid idle", {15'h0, host_rvalid}, 16'h0);

        // R4 refused while master set
        wr(2'd0, 16'h0094);
        chk("R4 no req", {15'h0, eng_req}, 16'h0);
        rd(2'd0, 16'h0000, "R4 cmd held");

        // R2 AND mask
        wr(2'd3, 16'hFF7F);
        rd(2'd3, 16'h8000, "R2 int");
        chk("R5 irq high", {15'h0, irq}, 16'h1);
        wr(2'd3, 16'h0000);
        rd(2'd3, 16'h0000, "R2 int clear");
        chk("R5 irq low", {15'h0, irq}, 16'h0);

        // R7 / R6 / R5 configuration
        wr(2'd1, 16'h4041);
        chk("R7 rdy low", {15'h0, rdy}, 16'h0);
        rd(2'd1, 16'h4040, "R6 cfg low bits");
        wr(2'd1, 16'h0080);
        chk("R5 inverted polarity", {15'h0, irq}, 16'h1);
        chk("R7 rdy high", {15'h0, rdy}, 16'h1);
        wr(2'd1, 16'h40C0);
        chk("R5 restored", {15'h0, irq}, 16'h0);
        wr(2'd2, 16'hFFFF);
        rd(2'd2, 16'h0000, "R6 status ro");

        // R8 / R9 load without error, R4 while busy
        wr(2'd0, 16'h0013);
        chk("R8 req", {15'h0, eng_req}, 16'h1);
        chk("R8 op load", {14'h0, eng_op}, 16'h0);
        @(negedge clk);
        chk("R8 req pulse", {15'h0, eng_req}, 16'h0);
        wr(2'd0, 16'h0080);
        chk("R4 busy no req", {15'h0, eng_req}, 16'h0);
        rd(2'd0, 16'h0013, "R4 cmd busy");
        done(1'b0);
        rd(2'd3, 16'h8080, "R9 load done");
        rd(2'd2, 16'h0000, "R9 no err");
        chk("R9 irq", {15'h0, irq}, 16'h1);
        wr(2'd3, 16'h0000);

        // R9 program with error, R3 partial ack keeps errors
        wr(2'd0, 16'h001A);
        chk("R8 op prog", {14'h0, eng_op}, 16'h1);
        done(1'b1);
        rd(2'd3, 16'h8040, "R9 prog done");
        rd(2'd2, 16'h1400, "R9 prog err");
        wr(2'd3, 16'h8000);
        rd(2'd2, 16'h1400, "R3 err kept");
        wr(2'd3, 16'h0000);
        rd(2'd2, 16'h0000, "R3 err wiped");

        // R9 erase with error
        wr(2'd0, 16'h0095);
        chk("R8 op erase", {14'h0, eng_op}, 16'h2);
        done(1'b1);
        rd(2'd3, 16'h8020, "R9 erase done");
        rd(2'd2, 16'h0C00, "R9 erase err");
        wr(2'd3, 16'h0020);
        rd(2'd3, 16'h0020, "R2 keep class");
        rd(2'd2, 16'h0000, "R3 wipe on partial");

        // R13 same-edge ack and completion
        wr(2'd0, 16'h0000);
        chk("R8 load code 0", {15'h0, eng_req}, 16'h1);
        @(negedge clk);
        host_wr = 1'b1; host_sel = 2'd3; host_wdata = 16'h0000;
        eng_done = 1'b1; eng_err = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; eng_done = 1'b0; eng_err = 1'b0;
        rd(2'd3, 16'h8080, "R13 int");
        rd(2'd2, 16'h2400, "R13 status");
        wr(2'd3, 16'h0000);

        // R10 unknown code
        wr(2'd0, 16'h0055);
        chk("R10 no req", {15'h0, eng_req}, 16'h0);
        rd(2'd2, 16'h0400, "R10 status");
        rd(2'd3, 16'h8000, "R10 int");
        wr(2'd3, 16'h0000);

        // R12 housekeeping and no-op codes
        wr(2'd0, 16'h002C);
        rd(2'd3, 16'h8000, "R12 simple int");
        rd(2'd2, 16'h0000, "R12 simple status");
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h00B0);
        rd(2'd3, 16'h0000, "R12 nop int");
        rd(2'd0, 16'h00B0, "R12 nop cmd");

        // R11 reset command
        wr(2'd1, 16'h0000);
        chk("R11 pre rdy", {15'h0, rdy}, 16'h0);
        wr(2'd0, 16'h00F3);
        chk("R11 rdy", {15'h0, rdy}, 16'h1);
        rd(2'd3, 16'h8010, "R11 int");
        rd(2'd1, 16'h40C0, "R11 cfg");
        rd(2'd0, 16'h0000, "R11 cmd");
        rd(2'd2, 16'h0000, "R11 status");
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h00F0);
        rd(2'd3, 16'h8010, "R11 second code");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R14 actual=%0d_pending expected=0_pending", exp_q.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule